// File: doc/BRIEF.md
# Conditional command-stream skip unit

This unit handles one conditional-execute packet inside a command processor's dword stream. An upstream opcode decoder pulses `start` when the packet's payload begins. The unit then takes the payload from the input stream: a header dword, an optional second-register dword and a count dword. It works out a condition and then handles the next N stream dwords. When the condition holds, it forwards them downstream unchanged. When it does not, it accepts and discards them.

The condition comes from one of three sources, chosen per packet by the header's mode field. The first is a predicate bit that an earlier register-test packet left behind. The second is an equality test of two register values, read through a single register-file port over two consecutive cycles. The third is the current render mode, tested against a three-bit pass mask. Both stream sides are valid/ready. A dword moves only on a cycle where valid and ready are both high. While forwarding, `in_ready` mirrors `out_ready` and `out_valid` mirrors `in_valid`, so downstream back-pressure stalls the upstream source directly. In every other state `out_valid` is low. Outside a packet `in_ready` is low.

Top module: `cond_skip_unit`

## Requirements
- R1: After reset `busy`, `in_ready`, `out_valid`, `rf_rd` and `cfg_err` are all 0.
- R2: The mode is header bits 31:28 and the first register address is header bits 17:0. In modes 1 and 3 no register read is issued, and header bits 27:23 and 19:18 have no effect.
- R3: Mode 1: the condition equals `pred_bit` as seen in the evaluation cycle.
- R4: Mode 2: a second payload dword carries the second register address in bits 17:0 and precedes the count. The unit reads the first address and then the second address on two consecutive cycles. `rf_data` is returned one cycle after each read. The condition is true exactly when the two values are equal.
- R5: Mode 3: header bits 20, 21 and 22 pass render modes 0 (binning), 1 (tiled) and 2 (direct) respectively. The condition is true when the bit selected by `rmode` is set. `rmode` = 3 never passes.
- R6: With a true condition, the next N dwords leave on `out_data` in order and unchanged. `out_valid` is never high without `in_valid`.
- R7: With a false condition, the next N dwords are accepted from upstream while `out_valid` stays 0.
- R8: The count dword is a full 32-bit N. When N = 0, the packet ends with no further dword taken from the stream.
- R9: Mode values 0 and 4 to 15 give a false condition and set `cfg_err`, which stays 1 until reset.
- R10: `busy` rises the cycle after `start`. When it falls, exactly the packet's payload plus N dwords have been taken. `in_ready` is 0 whenever `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| start | input | 1 | payload of a conditional packet follows |
| busy | output | 1 | packet in progress |
| in_valid | input | 1 | upstream dword valid |
| in_ready | output | 1 | upstream dword accepted |
| in_data | input | 32 | upstream dword |
| out_valid | output | 1 | downstream dword valid |
| out_ready | input | 1 | downstream can accept |
| out_data | output | 32 | downstream dword |
| rf_rd | output | 1 | register read strobe |
| rf_addr | output | 18 | register read address |
| rf_data | input | 32 | read data, one cycle after `rf_rd` |
| pred_bit | input | 1 | stored predicate from a register test |
| rmode | input | 2 | current render mode |
| cfg_err | output | 1 | sticky reserved-mode flag |

## Verification
The bench builds the unit with its default 32-bit data and count widths and 18-bit addresses. Its register model gives equal values to addresses that share their two low bits, so random address pairs hit both equal and unequal compares often. The counts stay small, with zero included, so every packet completes. Random gaps on both stream sides push the pass and skip runs through stalls on either side, and a trailing dword offered after every packet exposes any over-consumption.

// File: rtl/cskip_pkg.sv
package cskip_pkg;
  localparam int unsigned MODE_LO = 28;
  localparam int unsigned MASK_LO = 20;
  localparam logic [3:0] CM_PRED  = 4'd1;
  localparam logic [3:0] CM_REGEQ = 4'd2;
  localparam logic [3:0] CM_RMODE = 4'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_REG1, S_CNT, S_RDA, S_RDB, S_EVAL, S_PASS, S_SKIP
  } cskip_st_t;
endpackage

// File: rtl/cskip_eval.sv
module cskip_eval #(
  parameter int DW = 32
) (
  input  logic [3:0]    mode,
  input  logic [2:0]    pass_mask,
  input  logic          pred,
  input  logic [1:0]    rmode,
  input  logic [DW-1:0] val_a,
  input  logic [DW-1:0] val_b,
  output logic          cond,
  output logic          rsvd
);
  import cskip_pkg::*;

  always_comb begin
    cond = 1'b0;
    rsvd = 1'b0;
    case (mode)
      CM_PRED:  cond = pred;
      CM_REGEQ: cond = (val_a == val_b);
      CM_RMODE: cond = (rmode != 2'd3) && pass_mask[rmode];
      default:  rsvd = 1'b1;
    endcase
  end
endmodule

// File: rtl/cskip_ctr.sv
module cskip_ctr #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic          is_zero,
  output logic          is_last
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign is_zero = (cnt_q == '0);
  assign is_last = (cnt_q == CW'(1));

  // R8
  ctr_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> (cnt_q != '0));
endmodule

// File: rtl/cskip_ctrl.sv
module cskip_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic in_valid,
  input  logic out_ready,
  input  logic hdr_regeq,
  input  logic mode_regeq,
  input  logic cnt_zero,
  input  logic cnt_last,
  input  logic cond,
  output logic in_ready,
  output logic out_valid,
  output logic cap_hdr,
  output logic cap_reg1,
  output logic cap_cnt,
  output logic rd_a,
  output logic rd_b,
  output logic eval_now,
  output logic dec,
  output logic busy
);
  import cskip_pkg::*;

  cskip_st_t st_q, st_d;
  logic acc;

  always_comb begin
    case (st_q)
      S_HDR, S_REG1, S_CNT, S_SKIP: in_ready = 1'b1;
      S_PASS:                       in_ready = out_ready;
      default:                      in_ready = 1'b0;
    endcase
  end

  assign acc       = in_valid && in_ready;
  assign out_valid = (st_q == S_PASS) && in_valid;
  assign cap_hdr   = (st_q == S_HDR)  && acc;
  assign cap_reg1  = (st_q == S_REG1) && acc;
  assign cap_cnt   = (st_q == S_CNT)  && acc;
  assign rd_a      = (st_q == S_RDA);
  assign rd_b      = (st_q == S_RDB);
  assign eval_now  = (st_q == S_EVAL);
  assign dec       = ((st_q == S_PASS) || (st_q == S_SKIP)) && acc;
  assign busy      = (st_q != S_IDLE);

  always_comb begin
    st_d = st_q;
    case (st_q)
      S_IDLE: if (start) st_d = S_HDR;
      S_HDR:  if (acc) st_d = hdr_regeq ? S_REG1 : S_CNT;
      S_REG1: if (acc) st_d = S_CNT;
      S_CNT:  if (acc) st_d = mode_regeq ? S_RDA : S_EVAL;
      S_RDA:  st_d = S_RDB;
      S_RDB:  st_d = S_EVAL;
      S_EVAL: st_d = cnt_zero ? S_IDLE : (cond ? S_PASS : S_SKIP);
      S_PASS, S_SKIP: if (dec && cnt_last) st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= S_IDLE;
    else        st_q <= st_d;
  end
endmodule

// File: rtl/cond_skip_unit.sv
module cond_skip_unit #(
  parameter int DW = 32,
  parameter int AW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          rf_rd,
  output logic [AW-1:0] rf_addr,
  input  logic [DW-1:0] rf_data,
  input  logic          pred_bit,
  input  logic [1:0]    rmode,
  output logic          cfg_err
);
  import cskip_pkg::*;

  localparam int CW = DW;

  logic [3:0]    mode_q;
  logic [2:0]    mask_q;
  logic [AW-1:0] reg0_q, reg1_q;
  logic [DW-1:0] val_a_q;
  logic          err_q;
  logic          cap_hdr, cap_reg1, cap_cnt, rd_a, rd_b, eval_now, dec;
  logic          cnt_zero, cnt_last, cond, rsvd, hdr_regeq;
  logic          unused_hdr_bits;

  assign unused_hdr_bits = ^{in_data[27:23], in_data[19:18]};
  assign hdr_regeq = (in_data[DW-1:MODE_LO] == CM_REGEQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= '0;
      mask_q  <= '0;
      reg0_q  <= '0;
      reg1_q  <= '0;
      val_a_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (cap_hdr) begin
        mode_q <= in_data[DW-1:MODE_LO];
        mask_q <= in_data[MASK_LO+2:MASK_LO];
        reg0_q <= in_data[AW-1:0];
      end
      if (cap_reg1)         reg1_q  <= in_data[AW-1:0];
      if (rd_b)             val_a_q <= rf_data;
      if (eval_now && rsvd) err_q   <= 1'b1;
    end
  end

  assign rf_rd    = rd_a || rd_b;
  assign rf_addr  = rd_b ? reg1_q : reg0_q;
  assign out_data = in_data;
  assign cfg_err  = err_q;

  cskip_ctrl u_ctrl (
    .clk, .rst_n, .start, .in_valid, .out_ready,
    .hdr_regeq, .mode_regeq(mode_q == CM_REGEQ),
    .cnt_zero, .cnt_last, .cond,
    .in_ready, .out_valid, .cap_hdr, .cap_reg1, .cap_cnt,
    .rd_a, .rd_b, .eval_now, .dec, .busy
  );

  cskip_ctr #(.CW(CW)) u_ctr (
    .clk, .rst_n, .load(cap_cnt), .load_val(in_data), .dec,
    .is_zero(cnt_zero), .is_last(cnt_last)
  );

  cskip_eval #(.DW(DW)) u_eval (
    .mode(mode_q), .pass_mask(mask_q), .pred(pred_bit), .rmode,
    .val_a(val_a_q), .val_b(rf_data), .cond, .rsvd
  );

  // R10
  idle_no_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !in_ready);

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err);

  // R6
  pass_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (in_valid && busy));

  // R4
  rf_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_rd && (rf_addr == reg0_q) && !rd_b) |=> rf_rd);
endmodule

// File: tb/cond_skip_unit_test.sv
module cond_skip_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        rf_rd;
  logic [17:0] rf_addr;
  logic [31:0] rf_data;
  logic        pred_bit = 1'b0;
  logic [1:0]  rmode = 2'd0;
  logic        cfg_err;

  int checks = 0;
  int errors = 0;
  bit exp_err = 1'b0;

  logic [31:0] src [0:63];
  logic [31:0] got [0:63];
  logic [17:0] addrs [0:7];

  always #5 clk = ~clk;

  cond_skip_unit uut (
    .clk, .rst_n, .start, .busy, .in_valid, .in_ready, .in_data,
    .out_valid, .out_ready, .out_data, .rf_rd, .rf_addr, .rf_data,
    .pred_bit, .rmode, .cfg_err
  );

  function automatic logic [31:0] rf_val(input logic [17:0] a);
    return {16'hC0DE, 14'h0, a[1:0]};
  endfunction

  always_ff @(posedge clk) if (rf_rd) rf_data <= rf_val(rf_addr);

  function automatic bit exp_cond(input logic [3:0] m, input logic [2:0] mk,
      input logic p, input logic [1:0] rm, input logic [17:0] a0, input logic [17:0] a1);
    case (m)
      4'd1: return p;
      4'd2: return rf_val(a0) == rf_val(a1);
      4'd3: return (rm != 2'd3) && mk[rm];
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_pkt(input logic [3:0] m, input logic [17:0] a0, input logic [17:0] a1,
      input logic [2:0] mk, input int n, input logic p, input logic [1:0] rm, input bit rdy_always);
    int total, idx, ocnt, acnt, exp_n, cyc;
    bit c, offered;
    string ctag;
    idx = 0; ocnt = 0; acnt = 0; offered = 0;
    src[0] = {m, 5'($urandom), mk, 2'($urandom), a0};
    total = 1;
    if (m == 4'd2) begin src[1] = {14'($urandom), a1}; total = 2; end
    src[total] = n; total++;
    for (int i = 0; i < n; i++) src[total + i] = $urandom;
    src[total + n] = 32'hDEAD_0000 | 32'(n);
    total = total + n;
    pred_bit = p; rmode = rm;
    c = exp_cond(m, mk, p, rm, a0, a1);
    exp_n = c ? n : 0;
    if (m == 4'd1) ctag = "R3";
    else if (m == 4'd2) ctag = "R4";
    else if (m == 4'd3) ctag = "R5";
    else begin ctag = "R9"; exp_err = 1'b1; end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    #1 chk(busy === 1'b1, "R10", 32'(busy), 1);
    for (cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      if (!offered) in_valid = (idx <= total) && ($urandom % 4 != 0);
      in_data = src[idx];
      out_ready = rdy_always || ($urandom % 3 != 0);
      #1;
      if (!busy) break;
      chk(!(out_valid && !in_valid), "R6", 32'(out_valid), 0);
      offered = in_valid && !in_ready;
      if (in_valid && in_ready) idx++;
      if (out_valid && out_ready && ocnt < 64) begin got[ocnt] = out_data; ocnt++; end
      if (rf_rd && acnt < 8) begin addrs[acnt] = rf_addr; acnt++; end
    end
    in_valid = 1'b0; offered = 0;
    chk(cyc < 4000, "R10", cyc, 0);
    chk(idx == total, (n == 0) ? "R8" : "R10", idx, total);
    chk(in_ready === 1'b0, "R10", 32'(in_ready), 0);
    chk(ocnt == exp_n, c ? "R6" : "R7", ocnt, exp_n);
    chk(ocnt == exp_n, ctag, ocnt, exp_n);
    for (int i = 0; i < ocnt && i < exp_n; i++)
      chk(got[i] === src[total - n + i], "R6", got[i], src[total - n + i]);
    chk(cfg_err === exp_err, "R9", 32'(cfg_err), 32'(exp_err));
    if (m == 4'd2) begin
      chk(acnt == 2, "R4", acnt, 2);
      if (acnt == 2) begin
        chk(addrs[0] === a0, "R4", 32'(addrs[0]), 32'(a0));
        chk(addrs[1] === a1, "R4", 32'(addrs[1]), 32'(a1));
      end
    end else chk(acnt == 0, "R2", acnt, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] m;
    void'($urandom(32'd20241));
    repeat (3) @(negedge clk);
    #1 chk({busy, in_ready, out_valid, rf_rd, cfg_err} === 5'b0, "R1",
           32'({busy, in_ready, out_valid, rf_rd, cfg_err}), 0);
    rst_n = 1'b1;
    run_pkt(4'd1, 18'h5, 18'h0, 3'b000, 3, 1'b1, 2'd0, 1'b1);
    run_pkt(4'd1, 18'h5, 18'h0, 3'b111, 4, 1'b0, 2'd0, 1'b0);
    run_pkt(4'd2, 18'h3FF01, 18'h00005, 3'b000, 5, 1'b0, 2'd0, 1'b0);
    run_pkt(4'd2, 18'h3FF01, 18'h00006, 3'b111, 5, 1'b1, 2'd0, 1'b0);
    for (int r = 0; r < 4; r++) begin
      run_pkt(4'd3, 18'h1, 18'h0, 3'b010, 2, 1'b1, 2'(r), 1'b0);
      run_pkt(4'd3, 18'h1, 18'h0, 3'b101, 2, 1'b0, 2'(r), 1'b1);
    end
    run_pkt(4'd1, 18'h0, 18'h0, 3'b000, 0, 1'b1, 2'd0, 1'b1);
    run_pkt(4'd2, 18'h2, 18'h2, 3'b000, 0, 1'b1, 2'd0, 1'b1);
    run_pkt(4'd0, 18'h0, 18'h0, 3'b111, 3, 1'b1, 2'd0, 1'b1);
    run_pkt(4'd3, 18'h0, 18'h0, 3'b111, 2, 1'b0, 2'd1, 1'b0);
    run_pkt(4'd9, 18'h0, 18'h0, 3'b111, 2, 1'b1, 2'd2, 1'b0);
    for (int k = 0; k < 60; k++) begin
      m = ($urandom % 8 == 0) ? 4'($urandom) : 4'(1 + $urandom % 3);
      run_pkt(m, 18'($urandom), 18'($urandom), 3'($urandom), int'($urandom % 12),
              1'($urandom), 2'($urandom), 1'($urandom % 2));
    end
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); exp_err = 1'b0;
    #1 chk(cfg_err === 1'b0, "R9", 32'(cfg_err), 0);
    rst_n = 1'b1;
    run_pkt(4'd1, 18'h0, 18'h0, 3'b000, 2, 1'b1, 2'd0, 1'b1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule